// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block decides, cycle by cycle, what a single SIMD core issues. The core keeps up to 32 thread groups (warps) resident. Each warp has 32 threads, and these run on 8 pipelined lanes. The threads are fed to the lanes as four back-to-back phases of 8. When a warp cannot continue because it waits on an earlier result or on memory, it is marked stalled and the scheduler issues another ready warp in its place. Each thread is delayed a little, but the lanes stay busy.

The scheduler holds two pieces of state for each warp. The first is a residency and stall state, driven by the launch, exit, stall and wake ports. The second is a 32-bit active-thread mask with a small stack for divergent branches. The stack supports three operations:

- split: narrows the mask to the taken threads.
- else: switches the mask to the threads that were not taken.
- join: restores the mask that was active before the split.

Every issue beat carries the warp number, the phase and the 8-bit lane mask for that phase.

Top module: `ws_scheduler`

## Requirements
- R1: While reset is held, and just after it, no warp is resident. `issue_valid`, `issue_phase`, `issue_lanes`, `idle_count` and `div_overflow` are all zero.
- R2: Launch and exit control residency.
  - A launch makes the warp resident and not stalled, with all 32 threads active and an empty divergence stack. It is eligible at the next selection.
  - A launch wins over an exit, stall, wake or divergence operation aimed at the same warp in the same cycle.
  - An exit removes the warp from selection.
- R3: A selected warp issues on four consecutive cycles with phases 0, 1, 2, 3 and the same warp number. In phase p, `issue_lanes` carries mask bits [8p+7:8p], read from the mask as it stood one cycle before the beat.
- R4: A new warp is chosen only when the scheduler is idle or the current warp is in phase 3. The choice is the first ready warp in ascending cyclic order, starting after the warp issued last. After reset the search starts at warp 0.
- R5: A stalled warp is never chosen. A stall registered in cycle t applies to selections made from cycle t+1 on. A stall and a wake for the same warp in the same cycle leave that warp stalled.
- R6: A wake clears the warp's stall state, and the warp may be chosen at the next selection point.
- R7: When a selection finds no ready warp, `issue_valid` is low, and `issue_phase` and `issue_lanes` are zero. `idle_count` increases by one for every cycle in which `issue_valid` is low.
- R8: `div_op` encoding is 0 none, 1 split, 2 else, 3 join. A split on a warp with mask M and taken set T pushes the entry {M & ~T, M} and sets the mask to M & T.
- R9: An else sets the mask to the not-taken set from the top stack entry. The stack is unchanged. On an empty stack it does nothing.
- R10: A join restores the mask saved by the top entry and pops that entry. On an empty stack it does nothing.
- R11: A split on a warp whose stack already holds 4 entries leaves the mask and the stack unchanged. It sets `div_overflow`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Launch a warp this cycle |
| launch_warp | input | 5 | Warp to launch |
| exit_valid | input | 1 | Retire a warp this cycle |
| exit_warp | input | 5 | Warp to retire |
| stall_valid | input | 1 | Mark a warp stalled |
| stall_warp | input | 5 | Warp to stall |
| wake_valid | input | 1 | Clear a warp's stall |
| wake_warp | input | 5 | Warp to wake |
| div_op | input | 2 | Divergence operation: 0 none, 1 split, 2 else, 3 join |
| div_warp | input | 5 | Warp the divergence operation applies to |
| div_taken | input | 32 | Threads taking the branch (split only) |
| issue_valid | output | 1 | An issue beat is present |
| issue_warp | output | 5 | Warp being issued |
| issue_phase | output | 2 | Phase of the beat, 0 to 3 |
| issue_lanes | output | 8 | Active lanes for this phase |
| idle_count | output | 16 | Count of cycles without an issue beat |
| div_overflow | output | 1 | Sticky flag: a split found its warp's stack full |

## Verification
The assertions check four behaviours on every cycle:
- The four-phase beat sequence keeps one warp number and steps the phase by one.
- A beat that starts an instruction always names a warp that was ready in the cycle before.
- Idle beats carry no lanes, and the idle counter moves in step with them.
- The overflow flag never falls.

The bench scenarios cover what a single cycle cannot show. These are the exact round-robin order across warps, the timing of stall, wake and exit against an instruction already in flight, and the mask values that follow split, else and join sequences. They also cover the rejected fifth split.

// File: rtl/ws_pkg.sv
// Shared types for the warp issue scheduler.
// Assumes: divergence operations arrive as a 2-bit code at the core boundary.
package ws_pkg;
    typedef enum logic [1:0] {
        DIV_NONE  = 2'd0,
        DIV_SPLIT = 2'd1,
        DIV_ELSE  = 2'd2,
        DIV_JOIN  = 2'd3
    } div_op_e;
endpackage

// File: rtl/ws_warp_table.sv
// Residency and stall state for every warp slot. It produces the ready vector.
// Assumes: launch wins over exit, stall and wake on the same slot; stall wins over wake.
module ws_warp_table #(
    parameter int NUM_WARPS = 32,
    localparam int WID_W = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_valid,
    input  logic [WID_W-1:0]     launch_warp,
    input  logic                 exit_valid,
    input  logic [WID_W-1:0]     exit_warp,
    input  logic                 stall_valid,
    input  logic [WID_W-1:0]     stall_warp,
    input  logic                 wake_valid,
    input  logic [WID_W-1:0]     wake_warp,
    output logic [NUM_WARPS-1:0] ready_vec
);
    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
        logic res_q;
        logic stl_q;
        logic hit_launch;
        assign hit_launch = launch_valid && (launch_warp == WID_W'(g));

        // Track whether this slot is resident and whether it is stalled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= 1'b0;
                stl_q <= 1'b0;
            end else if (hit_launch) begin
                res_q <= 1'b1;
                stl_q <= 1'b0;
            end else begin
                if (exit_valid && exit_warp == WID_W'(g)) res_q <= 1'b0;
                if (stall_valid && stall_warp == WID_W'(g)) stl_q <= 1'b1;
                else if (wake_valid && wake_warp == WID_W'(g)) stl_q <= 1'b0;
            end
        end

        assign ready_vec[g] = res_q & ~stl_q;
    end
endmodule

// File: rtl/ws_rr_picker.sv
// Round-robin choice of the first ready warp after the last issued one.
// Assumes: NUM_WARPS is a power of two, so the index wraps by truncation.
module ws_rr_picker #(
    parameter int NUM_WARPS = 32,
    localparam int WID_W = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] ready_vec,
    input  logic [WID_W-1:0]     last_warp,
    output logic                 found,
    output logic [WID_W-1:0]     pick
);
    logic [WID_W-1:0] idx;

    // Scan every slot once in cyclic order from last_warp+1.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx   = '0;
        for (int i = 1; i <= NUM_WARPS; i++) begin
            idx = last_warp + WID_W'(i);
            if (!found && ready_vec[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end
endmodule

// File: rtl/ws_div_stack.sv
// Active-thread mask of one warp, with a divergence stack of {else, reconverge} masks.
// Assumes: clear (launch) wins over any operation; a full-stack split is rejected and reported.
module ws_div_stack
    import ws_pkg::*;
#(
    parameter int THREADS = 32,
    parameter int DEPTH   = 4,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               op_valid,
    input  div_op_e            op,
    input  logic [THREADS-1:0] taken,
    output logic [THREADS-1:0] mask,
    output logic               ovf_req
);
    logic [THREADS-1:0] else_q [DEPTH];
    logic [THREADS-1:0] rec_q  [DEPTH];
    logic [SP_W-1:0]    sp_q;
    logic [IDX_W-1:0]   push_idx;
    logic [IDX_W-1:0]   top_idx;
    logic               full;
    logic               empty;

    assign push_idx = IDX_W'(sp_q);
    assign top_idx  = IDX_W'(sp_q - 1'b1);
    assign full     = (sp_q == SP_W'(DEPTH));
    assign empty    = (sp_q == '0);
    assign ovf_req  = op_valid && !clear && (op == DIV_SPLIT) && full;

    // Apply split / else / join to the mask and stack; launch restores all threads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            sp_q <= '0;
        end else if (clear) begin
            mask <= '1;
            sp_q <= '0;
        end else if (op_valid) begin
            case (op)
                DIV_SPLIT: if (!full) begin
                    else_q[push_idx] <= mask & ~taken;
                    rec_q[push_idx]  <= mask;
                    mask             <= mask & taken;
                    sp_q             <= sp_q + 1'b1;
                end
                DIV_ELSE: if (!empty) mask <= else_q[top_idx];
                DIV_JOIN: if (!empty) begin
                    mask <= rec_q[top_idx];
                    sp_q <= sp_q - 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ws_scheduler.sv
// Warp issue scheduler for one SIMD core: picks a ready warp round-robin and issues it as
// PHASES consecutive beats of LANES threads, masked by the warp's divergence state.
// Assumes: NUM_WARPS and PHASES are powers of two; a new warp is chosen only between instructions.
module ws_scheduler
    import ws_pkg::*;
#(
    parameter int NUM_WARPS   = 32,
    parameter int LANES       = 8,
    parameter int PHASES      = 4,
    parameter int STACK_DEPTH = 4,
    parameter int IDLE_W      = 16,
    localparam int THREADS = LANES * PHASES,
    localparam int WID_W   = $clog2(NUM_WARPS),
    localparam int PH_W    = $clog2(PHASES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_valid,
    input  logic [WID_W-1:0]   launch_warp,
    input  logic               exit_valid,
    input  logic [WID_W-1:0]   exit_warp,
    input  logic               stall_valid,
    input  logic [WID_W-1:0]   stall_warp,
    input  logic               wake_valid,
    input  logic [WID_W-1:0]   wake_warp,
    input  logic [1:0]         div_op,
    input  logic [WID_W-1:0]   div_warp,
    input  logic [THREADS-1:0] div_taken,
    output logic               issue_valid,
    output logic [WID_W-1:0]   issue_warp,
    output logic [PH_W-1:0]    issue_phase,
    output logic [LANES-1:0]   issue_lanes,
    output logic [IDLE_W-1:0]  idle_count,
    output logic               div_overflow
);
    logic [NUM_WARPS-1:0] ready_vec;
    logic [THREADS-1:0]   warp_mask [NUM_WARPS];
    logic [NUM_WARPS-1:0] ovf_req;
    logic                 pick_found;
    logic [WID_W-1:0]     pick_warp;
    logic [WID_W-1:0]     last_q;
    logic                 act_q;
    logic [WID_W-1:0]     warp_q;
    logic [PH_W-1:0]      phase_q;
    logic [LANES-1:0]     lanes_q;
    logic [IDLE_W-1:0]    idle_q;
    logic                 ovf_q;
    logic                 sel_point;
    logic                 nxt_act;
    logic [WID_W-1:0]     nxt_warp;
    logic [PH_W-1:0]      nxt_phase;
    logic [THREADS-1:0]   nxt_mask;
    logic [LANES-1:0]     nxt_lanes;

    ws_warp_table #(.NUM_WARPS(NUM_WARPS)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_valid (launch_valid),
        .launch_warp  (launch_warp),
        .exit_valid   (exit_valid),
        .exit_warp    (exit_warp),
        .stall_valid  (stall_valid),
        .stall_warp   (stall_warp),
        .wake_valid   (wake_valid),
        .wake_warp    (wake_warp),
        .ready_vec    (ready_vec)
    );

    ws_rr_picker #(.NUM_WARPS(NUM_WARPS)) u_picker (
        .ready_vec (ready_vec),
        .last_warp (last_q),
        .found     (pick_found),
        .pick      (pick_warp)
    );

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_stack
        ws_div_stack #(.THREADS(THREADS), .DEPTH(STACK_DEPTH)) u_stack (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (launch_valid && launch_warp == WID_W'(g)),
            .op_valid (div_warp == WID_W'(g)),
            .op       (div_op_e'(div_op)),
            .taken    (div_taken),
            .mask     (warp_mask[g]),
            .ovf_req  (ovf_req[g])
        );
    end

    assign sel_point = !act_q || (phase_q == PH_W'(PHASES - 1));

    // Choose the next beat: advance the phase, or pick a new warp between instructions.
    always_comb begin
        nxt_act   = act_q;
        nxt_warp  = warp_q;
        nxt_phase = phase_q + 1'b1;
        if (sel_point) begin
            nxt_act   = pick_found;
            nxt_warp  = pick_found ? pick_warp : '0;
            nxt_phase = '0;
        end
    end

    assign nxt_mask  = warp_mask[nxt_warp];
    assign nxt_lanes = nxt_act ? nxt_mask[int'(nxt_phase) * LANES +: LANES] : '0;

    // Register the issue beat, the round-robin pointer, the idle counter and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            warp_q  <= '0;
            phase_q <= '0;
            lanes_q <= '0;
            last_q  <= WID_W'(NUM_WARPS - 1);
            idle_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            act_q   <= nxt_act;
            warp_q  <= nxt_warp;
            phase_q <= nxt_phase;
            lanes_q <= nxt_lanes;
            if (sel_point && pick_found) last_q <= pick_warp;
            if (!nxt_act) idle_q <= idle_q + 1'b1;
            if (|ovf_req) ovf_q <= 1'b1;
        end
    end

    assign issue_valid  = act_q;
    assign issue_warp   = warp_q;
    assign issue_phase  = phase_q;
    assign issue_lanes  = lanes_q;
    assign idle_count   = idle_q;
    assign div_overflow = ovf_q;
endmodule

// File: rtl/ws_scheduler_chk.sv
// Property checker for the warp issue scheduler, bound to every ws_scheduler instance.
// Assumes: it sees the ports plus the ready vector from the warp table.
module ws_scheduler_chk #(
    parameter int NUM_WARPS = 32,
    parameter int LANES     = 8,
    parameter int PHASES    = 4,
    parameter int IDLE_W    = 16,
    localparam int WID_W = $clog2(NUM_WARPS),
    localparam int PH_W  = $clog2(PHASES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic [WID_W-1:0]     issue_warp,
    input logic [PH_W-1:0]      issue_phase,
    input logic [LANES-1:0]     issue_lanes,
    input logic [IDLE_W-1:0]    idle_count,
    input logic                 div_overflow,
    input logic [NUM_WARPS-1:0] ready_vec
);
    logic [NUM_WARPS-1:0] ready_d;
    logic                 run_d;

    // Keep one cycle of ready history and a flag that marks the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_d <= '0;
            run_d   <= 1'b0;
        end else begin
            ready_d <= ready_vec;
            run_d   <= 1'b1;
        end
    end

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_phase != PH_W'(PHASES - 1) |=>
        issue_valid && issue_phase == $past(issue_phase) + 1'b1 && issue_warp == $past(issue_warp));

    // R5
    issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_phase == '0 |-> ready_d[issue_warp]);

    // R7
    quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> issue_lanes == '0 && issue_phase == '0);

    // R7
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_d |-> idle_count == $past(idle_count) + (issue_valid ? 1'b0 : 1'b1));

    // R11
    no_overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_overflow |=> div_overflow);
endmodule

bind ws_scheduler ws_scheduler_chk #(
    .NUM_WARPS (NUM_WARPS),
    .LANES     (LANES),
    .PHASES    (PHASES),
    .IDLE_W    (IDLE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_valid  (issue_valid),
    .issue_warp   (issue_warp),
    .issue_phase  (issue_phase),
    .issue_lanes  (issue_lanes),
    .idle_count   (idle_count),
    .div_overflow (div_overflow),
    .ready_vec    (ready_vec)
);

// File: tb/ws_scheduler_bench.sv
// Self-checking bench: a cycle model built from the requirements, directed scenarios and a
// seeded random mix, compared at every falling edge.
module ws_scheduler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_valid = 0, exit_valid = 0, stall_valid = 0, wake_valid = 0;
    logic [4:0]  launch_warp = 0, exit_warp = 0, stall_warp = 0, wake_warp = 0, div_warp = 0;
    logic [1:0]  div_op = 0;
    logic [31:0] div_taken = 0;
    logic        issue_valid;
    logic [4:0]  issue_warp;
    logic [1:0]  issue_phase;
    logic [7:0]  issue_lanes;
    logic [15:0] idle_count;
    logic        div_overflow;

    int n_checks = 0;
    int n_fails  = 0;
    string tag = "R1 reset";

    always #(CLK_PERIOD / 2) clk = ~clk;

    ws_scheduler u_ws_scheduler (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_warp(launch_warp),
        .exit_valid(exit_valid), .exit_warp(exit_warp),
        .stall_valid(stall_valid), .stall_warp(stall_warp),
        .wake_valid(wake_valid), .wake_warp(wake_warp),
        .div_op(div_op), .div_warp(div_warp), .div_taken(div_taken),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_phase(issue_phase),
        .issue_lanes(issue_lanes), .idle_count(idle_count), .div_overflow(div_overflow)
    );

    // ---------------- reference model ----------------
    logic        m_res [NW];
    logic        m_stl [NW];
    logic [31:0] m_mask [NW];
    int          m_sp [NW];
    logic [31:0] m_else [NW][4];
    logic [31:0] m_rec [NW][4];
    int          m_ptr, m_cur, m_ph;
    logic        m_act, m_ovf;
    logic [7:0]  m_lanes;
    logic [15:0] m_idle;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                m_res[w] = 0; m_stl[w] = 0; m_mask[w] = 0; m_sp[w] = 0;
            end
            m_ptr = NW - 1; m_cur = 0; m_ph = 0; m_act = 0; m_ovf = 0; m_lanes = 0; m_idle = 0;
        end else begin
            bit found;
            found = 0;
            if (!m_act || m_ph == 3) begin
                for (int i = 1; i <= NW; i++) begin
                    int idx;
                    idx = (m_ptr + i) % NW;
                    if (!found && m_res[idx] && !m_stl[idx]) begin
                        found = 1; m_cur = idx;
                    end
                end
                m_act = found; m_ph = 0;
                if (found) m_ptr = m_cur; else m_cur = 0;
            end else begin
                m_ph = m_ph + 1;
            end
            m_lanes = m_act ? 8'((m_mask[m_cur] >> (8 * m_ph)) & 32'hFF) : 8'h00;
            if (!m_act) m_idle = m_idle + 1;
            if (div_op != 0 && !(launch_valid && launch_warp == div_warp)) begin
                int w, s;
                w = div_warp; s = m_sp[w];
                case (div_op)
                    2'd1: if (s == 4) m_ovf = 1;
                          else begin
                              m_else[w][s] = m_mask[w] & ~div_taken;
                              m_rec[w][s]  = m_mask[w];
                              m_mask[w]    = m_mask[w] & div_taken;
                              m_sp[w]      = s + 1;
                          end
                    2'd2: if (s > 0) m_mask[w] = m_else[w][s-1];
                    2'd3: if (s > 0) begin m_mask[w] = m_rec[w][s-1]; m_sp[w] = s - 1; end
                    default: ;
                endcase
            end
            if (exit_valid && !(launch_valid && launch_warp == exit_warp)) m_res[exit_warp] = 0;
            if (stall_valid && !(launch_valid && launch_warp == stall_warp)) m_stl[stall_warp] = 1;
            if (wake_valid && !(launch_valid && launch_warp == wake_warp) &&
                !(stall_valid && stall_warp == wake_warp)) m_stl[wake_warp] = 0;
            if (launch_valid) begin
                m_res[launch_warp] = 1; m_stl[launch_warp] = 0;
                m_mask[launch_warp] = '1; m_sp[launch_warp] = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk({tag, " / R3 issue_valid"}, 64'(issue_valid), 64'(m_act));
            chk({tag, " / R3 issue_warp"},  64'(issue_warp),  64'(m_cur));
            chk({tag, " / R3 issue_phase"}, 64'(issue_phase), 64'(m_ph));
            chk({tag, " / R3 issue_lanes"}, 64'(issue_lanes), 64'(m_lanes));
            chk({tag, " / R7 idle_count"},  64'(idle_count),  64'(m_idle));
            chk({tag, " / R11 div_overflow"}, 64'(div_overflow), 64'(m_ovf));
        end
    end

    // ---------------- stimulus helpers (each call spans one cycle, from a falling edge) -----
    task automatic clear_in();
        launch_valid = 0; exit_valid = 0; stall_valid = 0; wake_valid = 0; div_op = 0;
    endtask
    task automatic do_launch(input int w);
        launch_valid = 1; launch_warp = 5'(w); @(negedge clk); clear_in();
    endtask
    task automatic do_exit(input int w);
        exit_valid = 1; exit_warp = 5'(w); @(negedge clk); clear_in();
    endtask
    task automatic do_stall(input int w);
        stall_valid = 1; stall_warp = 5'(w); @(negedge clk); clear_in();
    endtask
    task automatic do_wake(input int w);
        wake_valid = 1; wake_warp = 5'(w); @(negedge clk); clear_in();
    endtask
    task automatic do_div(input int w, input logic [1:0] op, input logic [31:0] t);
        div_op = op; div_warp = 5'(w); div_taken = t; @(negedge clk); clear_in();
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wait_phase0(output int w);
        w = -1;
        for (int k = 0; k < 64 && w < 0; k++) begin
            @(negedge clk);
            if (issue_valid && issue_phase == 0) w = issue_warp;
        end
    endtask
    task automatic lanes_of_next(output logic [31:0] m);
        int w;
        wait_phase0(w);
        m[7:0] = issue_lanes;
        for (int p = 1; p < 4; p++) begin
            @(negedge clk);
            m[8*p +: 8] = issue_lanes;
        end
    endtask
    function automatic int next_in_set(input int a);
        return (a == 2) ? 5 : (a == 5) ? 9 : 2;
    endfunction

    // ---------------- directed and random scenarios ----------------
    initial begin
        int w, prev, i0;
        logic [31:0] m;
        void'($urandom(32'h5EED_0451));
        repeat (3) @(negedge clk);
        chk("R1 issue_valid in reset", 64'(issue_valid), 0);
        chk("R1 idle_count in reset", 64'(idle_count), 0);
        chk("R1 div_overflow in reset", 64'(div_overflow), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 nothing resident after reset", 64'(issue_valid), 0);

        tag = "R2 launch";
        do_launch(5); do_launch(2); do_launch(9);
        idle(12);
        wait_phase0(w);
        chk("R2 launched warp issues with full lanes", 64'(issue_lanes), 64'hFF);

        tag = "R4 rotation";
        prev = w;
        for (int k = 0; k < 6; k++) begin
            wait_phase0(w);
            chk("R4 round-robin successor", 64'(w), 64'(next_in_set(prev)));
            prev = w;
        end

        tag = "R5 stall";
        do_stall(5);
        idle(5);
        for (int k = 0; k < 6; k++) begin
            wait_phase0(w);
            chk("R5 stalled warp 5 skipped", 64'(w == 5), 0);
        end

        tag = "R6 wake";
        do_wake(5);
        i0 = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (issue_valid && issue_phase == 0 && issue_warp == 5) i0 = 1;
        end
        chk("R6 woken warp 5 issues again", 64'(i0), 1);

        tag = "R7 idle";
        do_exit(2); do_exit(5); do_exit(9);
        idle(8);
        i0 = idle_count;
        idle(5);
        chk("R7 issue_valid low with no ready warp", 64'(issue_valid), 0);
        chk("R7 idle_count advances by 5", 64'(idle_count - 16'(i0)), 5);

        tag = "R8 split";
        do_launch(3);
        do_div(3, 2'd1, 32'h0F0F_00FF);
        idle(5);
        lanes_of_next(m);
        chk("R8 split mask = taken threads", 64'(m), 64'h0F0F_00FF);

        tag = "R9 else";
        do_div(3, 2'd2, 32'h0);
        idle(5);
        lanes_of_next(m);
        chk("R9 else mask = not-taken threads", 64'(m), 64'hF0F0_FF00);

        tag = "R10 join";
        do_div(3, 2'd3, 32'h0);
        idle(5);
        lanes_of_next(m);
        chk("R10 join restores full mask", 64'(m), 64'hFFFF_FFFF);
        do_div(3, 2'd3, 32'h0);
        do_div(3, 2'd2, 32'h0);
        idle(5);
        lanes_of_next(m);
        chk("R10 join/else on empty stack ignored", 64'(m), 64'hFFFF_FFFF);

        tag = "R11 overflow";
        for (int k = 0; k < 4; k++) do_div(3, 2'd1, ~(32'h1 << k));
        idle(2);
        chk("R11 four splits fit", 64'(div_overflow), 0);
        do_div(3, 2'd1, ~32'h10);
        idle(5);
        chk("R11 fifth split flags overflow", 64'(div_overflow), 1);
        lanes_of_next(m);
        chk("R11 rejected split leaves mask", 64'(m), 64'hFFFF_FFF0);

        tag = "R5 stall beats wake";
        stall_valid = 1; stall_warp = 3; wake_valid = 1; wake_warp = 3;
        @(negedge clk); clear_in();
        idle(6);
        chk("R5 stall wins over same-cycle wake", 64'(issue_valid), 0);
        do_wake(3);

        tag = "R2 launch priority";
        launch_valid = 1; launch_warp = 7; exit_valid = 1; exit_warp = 7;
        @(negedge clk); clear_in();
        i0 = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (issue_valid && issue_phase == 0 && issue_warp == 7) i0 = 1;
        end
        chk("R2 launch wins over same-cycle exit", 64'(i0), 1);

        tag = "R4 R5 R6 R8 R9 R10 random mix";
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 12 == 0) begin launch_valid = 1; launch_warp = 5'($urandom % 8); end
            if ($urandom % 40 == 0) begin exit_valid = 1; exit_warp = 5'($urandom % 8); end
            if ($urandom % 5 == 0)  begin stall_valid = 1; stall_warp = 5'($urandom % 8); end
            if ($urandom % 3 == 0)  begin wake_valid = 1; wake_warp = 5'($urandom % 8); end
            if ($urandom % 4 == 0)  begin
                div_op = 2'($urandom % 4); div_warp = 5'($urandom % 8); div_taken = $urandom;
            end
            @(negedge clk);
            clear_in();
        end
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule